// File: doc/BRIEF.md
# Non-Volatile Program Cycle Sequencer

This block decides when a freshly received setting is copied into its non-volatile slot, and it times that copy. It watches a program-request pin against the position of the serial frame. A request is taken only if the pin rose after the frame's start bit and is still high at the clock edge that closes the data field. The block then runs an erase/write window, counted in serial clock cycles. During the window it holds a ready output low and tells the serial block to ignore its data input and keep its data output quiet. When the window ends it pulses a write strobe that carries the latched slot address.

The busy indication depends on a supply-good input. If the supply is low when the request arrives, the window does not start and the ready output stays high, so the host can see that nothing was stored. The request pin must stay high for the whole window. If it drops early, or if the supply fails during the window, the copy is abandoned and the stored value is left unchanged. Once a window ends, a new one needs a fresh rising edge of the request pin inside a frame.

Top module: `nvprog_ctrl`

## Requirements
- R1: After reset, `ready_o` is 1, `ser_hold` is 0 and `nv_wr_stb` is 0.
- R2: If `prog_in` rises while `frm_armed` is 1, including in the commit cycle itself, and is 1 in the cycle where `frm_commit` is 1 with `supply_ok` 1, then `ready_o` is 0 and `ser_hold` is 1 from the next cycle.
- R3: A `prog_in` that went high before `frm_armed` was set and stays high through the commit starts no cycle: `ready_o` stays 1.
- R4: If `prog_in` is 0 in the commit cycle, no cycle starts, even if it rose earlier in the frame.
- R5: If `supply_ok` is 0 in the commit cycle, `ready_o` stays 1 and no strobe is issued.
- R6: An uninterrupted cycle keeps `ready_o` low for exactly PROG_TICKS+1 cycles, where PROG_TICKS = CLK_KHZ*PROG_MS. `nv_wr_stb` is high for exactly one cycle, which is the last low cycle of `ready_o`.
- R7: In the cycle after the strobe, `ready_o` is 1 and `ser_hold` is 0.
- R8: If `prog_in` is 0 during the cycle, the next cycle has `ready_o` 1, and no strobe is issued for that request.
- R9: If `supply_ok` is 0 during the cycle, the next cycle has `ready_o` 1, and no strobe is issued for that request.
- R10: After a completed cycle, a `prog_in` that is still high starts nothing in a later frame. A low period followed by a new rise inside a frame is accepted again.
- R11: `nv_wr_addr` at the strobe equals `frm_addr` as sampled in the commit cycle; later changes of `frm_addr` do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, kept running during a cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| prog_in | input | 1 | Program request pin |
| frm_armed | input | 1 | High from the start bit until the frame closes |
| frm_commit | input | 1 | One-cycle pulse in the cycle that closes the data field |
| frm_addr | input | AW | Slot address of the current frame |
| supply_ok | input | 1 | Supply high enough to program |
| nv_wr_stb | output | 1 | One-cycle copy strobe to the non-volatile store |
| nv_wr_addr | output | AW | Slot address for the copy |
| ready_o | output | 1 | 1 = ready, 0 = program cycle in progress |
| ser_hold | output | 1 | Tells the serial block to ignore DI and keep DO quiet |

## Verification
The hardest situation to reach from the ports is the one where the request pin is already high when a frame arms. It looks like a valid request at the commit edge, but it must be refused because it never rose inside the frame. The stimulus reaches it in two ways. It raises the pin before arming. It also leaves the pin high after a completed cycle and runs a second frame. In both cases it checks that the ready output never drops. The full-length window is walked cycle by cycle so that the strobe position and the low-time count can be compared with the parameter.

// File: rtl/pnv_pkg.sv
// Shared types for the program cycle sequencer.
package pnv_pkg;
    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_RUN    = 2'd1,
        PS_STROBE = 2'd2
    } pnv_state_e;
endpackage

// File: rtl/pnv_req_qual.sv
// Request qualifier: turns the raw program pin into a single request pulse.
// A request is raised only when the pin rose while the frame was armed and
// the pin is high in the commit cycle. Assumes frm_commit is a one-cycle pulse.
module pnv_req_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_in,
    input  logic frm_armed,
    input  logic frm_commit,
    input  logic idle,
    output logic req
);
    logic prog_q;
    logic rose_seen;
    logic rise_now;

    assign rise_now = prog_in & ~prog_q;

    // Delayed pin copy; reset high so a pin held high through reset is no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prog_q <= 1'b1;
        else        prog_q <= prog_in;
    end

    // Remember a rise inside the armed frame; forget it outside the frame or while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rose_seen <= 1'b0;
        else if (!frm_armed || !idle)  rose_seen <= 1'b0;
        else if (rise_now)             rose_seen <= 1'b1;
    end

    // Request pulse in the commit cycle.
    always_comb begin
        req = idle & frm_commit & prog_in & (rose_seen | (rise_now & frm_armed));
    end
endmodule

// File: rtl/pnv_cycle_timer.sv
// Down-counter that measures the erase/write window in clock cycles.
// After load it reports expiry once TICKS-1 further enabled cycles have passed.
// Assumes TICKS >= 2.
module pnv_cycle_timer #(
    parameter int TICKS = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;

    logic [CW-1:0] cnt;

    // Load the window length or count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (load)                   cnt <= CW'(TICKS - 1);
        else if (run && cnt != '0)       cnt <= cnt - 1'b1;
    end

    // Expiry flag.
    always_comb expired = (cnt == '0);
endmodule

// File: rtl/pnv_seq_fsm.sv
// Sequencer: idle -> run -> strobe -> idle. The run state ends early when
// the pin drops or the supply fails. Latches the slot address on acceptance.
module pnv_seq_fsm
    import pnv_pkg::*;
#(
    parameter int AW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          prog_in,
    input  logic          supply_ok,
    input  logic          expired,
    input  logic [AW-1:0] addr_in,
    output logic          load,
    output logic          run,
    output logic          busy,
    output logic          idle,
    output logic          stb,
    output logic [AW-1:0] addr_q
);
    pnv_state_e state;

    // State transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_IDLE;
        end else begin
            unique case (state)
                PS_IDLE:   if (req && supply_ok) state <= PS_RUN;
                PS_RUN: begin
                    if (!prog_in || !supply_ok) state <= PS_IDLE;
                    else if (expired)           state <= PS_STROBE;
                end
                PS_STROBE: state <= PS_IDLE;
                default:   state <= PS_IDLE;
            endcase
        end
    end

    // Address latch at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    addr_q <= '0;
        else if (state == PS_IDLE && req && supply_ok) addr_q <= addr_in;
    end

    // Decoded controls.
    always_comb begin
        idle = (state == PS_IDLE);
        load = idle & req & supply_ok;
        run  = (state == PS_RUN);
        stb  = (state == PS_STROBE);
        busy = ~idle;
    end
endmodule

// File: rtl/nvprog_ctrl.sv
// Top of the program cycle sequencer. Qualifies the program pin against the
// frame, times the write window from the serial clock and issues the copy
// strobe. Assumes the serial clock runs for the whole window.
module nvprog_ctrl #(
    parameter int CLK_KHZ = 1000,
    parameter int PROG_MS = 3,
    parameter int AW      = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_in,
    input  logic          frm_armed,
    input  logic          frm_commit,
    input  logic [AW-1:0] frm_addr,
    input  logic          supply_ok,
    output logic          nv_wr_stb,
    output logic [AW-1:0] nv_wr_addr,
    output logic          ready_o,
    output logic          ser_hold
);
    localparam int PROG_TICKS = CLK_KHZ * PROG_MS;

    logic req, load, run, busy, idle, expired;

    pnv_req_qual u_qual (
        .clk(clk), .rst_n(rst_n), .prog_in(prog_in), .frm_armed(frm_armed),
        .frm_commit(frm_commit), .idle(idle), .req(req)
    );

    pnv_cycle_timer #(.TICKS(PROG_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .run(run), .expired(expired)
    );

    pnv_seq_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .prog_in(prog_in),
        .supply_ok(supply_ok), .expired(expired), .addr_in(frm_addr),
        .load(load), .run(run), .busy(busy), .idle(idle), .stb(nv_wr_stb),
        .addr_q(nv_wr_addr)
    );

    // Output drive: ready is the inverse of the busy state.
    always_comb begin
        ready_o  = ~busy;
        ser_hold = busy;
    end
endmodule

// File: rtl/nvprog_ctrl_chk.sv
// Checker for the program cycle sequencer, attached by bind.
module nvprog_ctrl_chk #(
    parameter int AW = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prog_in,
    input logic          frm_commit,
    input logic          supply_ok,
    input logic          nv_wr_stb,
    input logic [AW-1:0] nv_wr_addr,
    input logic          ready_o,
    input logic          ser_hold
);
    // R2
    start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> $past(frm_commit && prog_in && supply_ok));
    // R6
    stb_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_stb |-> !ready_o);
    // R6
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_stb |=> !nv_wr_stb);
    // R7
    ready_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_stb |=> (ready_o && !ser_hold));
    // R8
    prog_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !nv_wr_stb && !prog_in) |=> (ready_o && !nv_wr_stb));
    // R9
    supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !nv_wr_stb && !supply_ok) |=> (ready_o && !nv_wr_stb));
    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && $past(!ready_o)) |-> $stable(nv_wr_addr));
endmodule

bind nvprog_ctrl nvprog_ctrl_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_in(prog_in), .frm_commit(frm_commit),
    .supply_ok(supply_ok), .nv_wr_stb(nv_wr_stb), .nv_wr_addr(nv_wr_addr),
    .ready_o(ready_o), .ser_hold(ser_hold)
);

// File: tb/nvprog_ctrl_tb_top.sv
module nvprog_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICKS      = 1000 * 3;
    localparam int NROWS      = 6;

    // Row: {pre_high, rise_in_frame, high_at_commit, supply, expect_start, req_no}
    localparam logic [8:0] VEC [NROWS] = '{
        {5'b0_1_1_1_1, 4'd2},   // R2 rise inside frame
        {5'b1_0_1_1_0, 4'd3},   // R3 high before arming
        {5'b0_1_0_1_0, 4'd4},   // R4 rose then fell
        {5'b0_1_1_0_0, 4'd5},   // R5 low supply
        {5'b0_0_1_1_1, 4'd2},   // R2 rise in commit cycle
        {5'b0_0_0_1_0, 4'd4}    // R4 no request at all
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_in = 1'b0, frm_armed = 1'b0, frm_commit = 1'b0, supply_ok = 1'b1;
    logic [0:0] frm_addr = 1'b0;
    logic nv_wr_stb, ready_o, ser_hold;
    logic [0:0] nv_wr_addr;

    int errors = 0, checks = 0, stb_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvprog_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .prog_in(prog_in), .frm_armed(frm_armed),
        .frm_commit(frm_commit), .frm_addr(frm_addr), .supply_ok(supply_ok),
        .nv_wr_stb(nv_wr_stb), .nv_wr_addr(nv_wr_addr), .ready_o(ready_o),
        .ser_hold(ser_hold)
    );

    always @(negedge clk) if (rst_n && nv_wr_stb) stb_seen++;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One frame; returns at the negedge after the commit edge.
    task automatic do_frame(input bit pre, input bit rise, input bit hc,
                            input bit sup, input bit a);
        @(negedge clk); prog_in = pre; supply_ok = sup;
        @(negedge clk); frm_armed = 1'b1;
        @(negedge clk); if (rise) prog_in = 1'b1;
        @(negedge clk); prog_in = hc; frm_commit = 1'b1; frm_addr = a;
        @(negedge clk); frm_commit = 1'b0; frm_armed = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", ready_o, 1);
        check("R1 hold", ser_hold, 0);
        check("R1 stb", nv_wr_stb, 0);

        // Table walk
        for (int i = 0; i < NROWS; i++) begin
            logic [8:0] v = VEC[i];
            s0 = stb_seen;
            do_frame(v[8], v[7], v[6], v[5], 1'b0);
            check($sformatf("R%0d row%0d ready", v[3:0], i), ready_o, v[4] ? 0 : 1);
            check($sformatf("R%0d row%0d hold", v[3:0], i), ser_hold, v[4] ? 1 : 0);
            // R8 abort by dropping the pin
            prog_in = 1'b0; supply_ok = 1'b1;
            repeat (3) @(negedge clk);
            check($sformatf("R8 row%0d ready", i), ready_o, 1);
            check($sformatf("R8 row%0d no stb", i), stb_seen - s0, 0);
        end

        // R6 R7 R11 full window
        begin
            int lows = 1, stb_at = -1;
            s0 = stb_seen;
            do_frame(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
            frm_addr = 1'b0;
            for (int n = 1; n <= TICKS + 1; n++) begin
                @(negedge clk);
                if (!ready_o) lows++;
                if (nv_wr_stb) begin
                    stb_at = n;
                    check("R11 addr at strobe", nv_wr_addr, 1);
                end
            end
            check("R6 low cycles", lows, TICKS + 1);
            check("R6 strobe position", stb_at, TICKS);
            check("R6 strobe count", stb_seen - s0, 1);
            check("R7 ready after", ready_o, 1);
            check("R7 hold after", ser_hold, 0);
        end

        // R10 pin still high: next frame refused, then fresh rise accepted
        do_frame(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R10 held pin refused", ready_o, 1);
        prog_in = 1'b0;
        do_frame(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R10 fresh rise accepted", ready_o, 0);
        s0 = stb_seen;
        repeat (20) @(negedge clk);
        prog_in = 1'b0;
        @(negedge clk);
        check("R8 abort mid window", ready_o, 1);
        repeat (2) @(negedge clk);
        check("R8 no strobe", stb_seen - s0, 0);

        // R9 supply drop mid window
        do_frame(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R9 started", ready_o, 0);
        s0 = stb_seen;
        repeat (15) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        check("R9 abort ready", ready_o, 1);
        supply_ok = 1'b1;
        repeat (TICKS + 5) @(negedge clk);
        check("R9 no strobe", stb_seen - s0, 0);
        check("R9 stays ready", ready_o, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule